// File: doc/BRIEF.md
# Transceiver Power-Mode Sequencer

This block is the control state machine that steps a low-power radio transceiver through its operating modes: Off, Hibernate, Doze, Idle, Receive and Transmit. It watches an active-low reset pin, an active-low attention pin, a level-sensitive RX/TX enable pin, a sleep request written through the register interface and a timer-comparator match. From these it drives the oscillator enable, the register-interface enable, the receiver and transmitter enables, an out-of-idle flag and a three-bit mode code.

The time each transition needs to settle is counted in clock cycles by one shared downcounter. The four counts are parameters: power-up settle (`BOOT_CYC`), hibernate wake (`HIB_WAKE_CYC`), doze wake (`DOZE_WAKE_CYC`) and RX/TX warm-up (`WARM_CYC`). Each count must be at least 1. The internal states are Off, Boot settle, Idle, Hibernate, Hibernate wake, Doze, Doze wake, Warm-up, Receive and Transmit. The named transitions are:

- power-up: Off to Boot.
- boot done: Boot to Idle.
- sleep: Idle to Hibernate, or Idle to Doze.
- pin wake: Hibernate to Hibernate wake, or Doze to Doze wake.
- timer wake: Doze to Doze wake.
- wake done: either wake state to Idle.
- start: Idle to Warm-up.
- activate: Warm-up to Receive, or Warm-up to Transmit.
- drop: Warm-up, Receive or Transmit back to Idle.

All inputs other than the reset pin are taken as already synchronous to `clk`.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, the block is in Off at once: `mode_code` is 0, `osc_en`, `spi_en`, `rx_en` and `tx_en` are 0, and `out_of_idle` is 1.
- R2: After `rst_n` rises, the first clock edge starts the boot settle. During the settle `osc_en` is 1, `spi_en` is 0 and `mode_code` stays 0. Idle (`mode_code` 3, `spi_en` 1) is reached on rising edge number `BOOT_CYC`+1.
- R3: In Idle, `mode_req_valid` high moves the block on the next edge to Hibernate (code 1) when `mode_req_doze` is 0, or to Doze (code 2) when `mode_req_doze` is 1.
- R4: In Hibernate, `osc_en` and `spi_en` are 0. When `attn_n` is seen low, the block enters the hibernate wake: code 1, `osc_en` 1, `spi_en` 0. It reaches Idle `HIB_WAKE_CYC` edges after that entry edge.
- R5: In Doze, `osc_en` is 1 and `spi_en` is 0. When `attn_n` is seen low, the block enters the doze wake (code 2) and reaches Idle `DOZE_WAKE_CYC` edges after that entry edge.
- R6: In Doze, `tmr_match` starts the doze wake only while `tmr_wake_en` is 1. With `tmr_wake_en` at 0 the match has no effect.
- R7: A rising edge on `rxtx_en` seen in Idle starts the warm-up, toward Receive when `rxtx_sel` is 0 or toward Transmit when it is 1. During the warm-up `mode_code` is 4 or 5 and `rx_en` and `tx_en` are 0. The matching enable rises `WARM_CYC` edges after the entry edge.
- R8: `rxtx_en` that is already high when the block reaches Idle, with no rising edge seen in Idle, starts no sequence.
- R9: `rxtx_en` low during warm-up, Receive or Transmit returns the block to Idle on the next edge.
- R10: A mode request during warm-up, Receive or Transmit is ignored.
- R11: When a rising edge on `rxtx_en` and a mode request occur in the same Idle cycle, the RX/TX start wins.
- R12: In Idle, `attn_n` low and `tmr_match` (even with `tmr_wake_en` at 1) leave the mode unchanged.
- R13: `out_of_idle` is 1 exactly when `mode_code` is not 3. `rx_en` and `tx_en` are never both 1. `spi_en` is 1 only in Idle, warm-up, Receive and Transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset pin; low holds Off |
| attn_n | input | 1 | Active-low attention pin, wakes Hibernate or Doze |
| rxtx_en | input | 1 | Level-sensitive RX/TX enable; rising edge starts, low drops to Idle |
| rxtx_sel | input | 1 | Programmed direction: 0 receive, 1 transmit |
| mode_req_valid | input | 1 | Sleep request from the register interface |
| mode_req_doze | input | 1 | Requested sleep: 0 Hibernate, 1 Doze |
| tmr_match | input | 1 | Timer-comparator match pulse |
| tmr_wake_en | input | 1 | Allows the timer match to wake Doze |
| osc_en | output | 1 | Oscillator enable |
| spi_en | output | 1 | Register-interface enable |
| rx_en | output | 1 | Receiver active |
| tx_en | output | 1 | Transmitter active |
| out_of_idle | output | 1 | High whenever not in Idle |
| mode_code | output | 3 | 0 Off, 1 Hibernate, 2 Doze, 3 Idle, 4 Receive, 5 Transmit |

## Verification
The bench runs the sequencer through a vector table of pin and request patterns, each held for a set number of edges. The patterns are sleep requests of both kinds, waking by attention, by timer match with its enable on and with it off, and RX/TX starts in both directions. Rows are placed one edge before and exactly at each settle boundary, so an off-by-one counter load is caught. Other rows separate a real wake from an ignored input: a match with wake disabled, attention or a match while in Idle, and a request while active. Further rows show which input wins when a start and a request arrive in the same cycle. Directed tests cover the asynchronous reset, the boot timing, and an enable held high through boot, which must not count as an edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_BOOT,
        ST_IDLE,
        ST_HIB,
        ST_HIB_WAKE,
        ST_DOZE,
        ST_DOZE_WAKE,
        ST_WARM,
        ST_RX,
        ST_TX
    } seq_state_e;

    typedef enum logic [2:0] {
        MC_OFF  = 3'd0,
        MC_HIB  = 3'd1,
        MC_DOZE = 3'd2,
        MC_IDLE = 3'd3,
        MC_RX   = 3'd4,
        MC_TX   = 3'd5
    } mode_code_e;

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= din;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import pwr_mode_pkg::*;
(
    input  seq_state_e  st,
    input  logic        dir_tx,
    output logic        osc_en,
    output logic        spi_en,
    output logic        rx_en,
    output logic        tx_en,
    output logic        out_of_idle,
    output logic [2:0]  mode_code
);
    always_comb begin
        osc_en      = 1'b1;
        spi_en      = 1'b0;
        rx_en       = 1'b0;
        tx_en       = 1'b0;
        out_of_idle = (st != ST_IDLE);
        mode_code   = MC_OFF;
        unique case (st)
            ST_OFF: begin
                osc_en    = 1'b0;
                mode_code = MC_OFF;
            end
            ST_BOOT:      mode_code = MC_OFF;
            ST_HIB: begin
                osc_en    = 1'b0;
                mode_code = MC_HIB;
            end
            ST_HIB_WAKE:  mode_code = MC_HIB;
            ST_DOZE,
            ST_DOZE_WAKE: mode_code = MC_DOZE;
            ST_IDLE: begin
                spi_en    = 1'b1;
                mode_code = MC_IDLE;
            end
            ST_WARM: begin
                spi_en    = 1'b1;
                mode_code = dir_tx ? MC_TX : MC_RX;
            end
            ST_RX: begin
                spi_en    = 1'b1;
                rx_en     = 1'b1;
                mode_code = MC_RX;
            end
            ST_TX: begin
                spi_en    = 1'b1;
                tx_en     = 1'b1;
                mode_code = MC_TX;
            end
            default: begin
                osc_en    = 1'b0;
                mode_code = MC_OFF;
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int BOOT_CYC      = 400000,
    parameter int HIB_WAKE_CYC  = 320000,
    parameter int DOZE_WAKE_CYC = 4800,
    parameter int WARM_CYC      = 2304
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       attn_n,
    input  logic       rxtx_en,
    input  logic       rxtx_sel,
    input  logic       mode_req_valid,
    input  logic       mode_req_doze,
    input  logic       tmr_match,
    input  logic       tmr_wake_en,
    output logic       osc_en,
    output logic       spi_en,
    output logic       rx_en,
    output logic       tx_en,
    output logic       out_of_idle,
    output logic [2:0] mode_code
);
    localparam int MAX_A   = (BOOT_CYC > HIB_WAKE_CYC) ? BOOT_CYC : HIB_WAKE_CYC;
    localparam int MAX_B   = (DOZE_WAKE_CYC > WARM_CYC) ? DOZE_WAKE_CYC : WARM_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    localparam logic [CW-1:0] BOOT_LD = CW'(BOOT_CYC - 1);
    localparam logic [CW-1:0] HIB_LD  = CW'(HIB_WAKE_CYC - 1);
    localparam logic [CW-1:0] DOZE_LD = CW'(DOZE_WAKE_CYC - 1);
    localparam logic [CW-1:0] WARM_LD = CW'(WARM_CYC - 1);

    seq_state_e    st_q, st_d;
    logic          dir_q;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          done;
    logic          en_rise;
    logic          start_go;

    rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxtx_en),
        .rise  (en_rise)
    );

    settle_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (done)
    );

    assign start_go = (st_q == ST_IDLE) && en_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            dir_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start_go)
                dir_q <= rxtx_sel;
        end
    end

    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (st_q)
            ST_OFF: begin
                st_d   = ST_BOOT;
                ld     = 1'b1;
                ld_val = BOOT_LD;
            end
            ST_BOOT: begin
                if (done)
                    st_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (en_rise) begin
                    st_d   = ST_WARM;
                    ld     = 1'b1;
                    ld_val = WARM_LD;
                end else if (mode_req_valid) begin
                    st_d = mode_req_doze ? ST_DOZE : ST_HIB;
                end
            end
            ST_HIB: begin
                if (!attn_n) begin
                    st_d   = ST_HIB_WAKE;
                    ld     = 1'b1;
                    ld_val = HIB_LD;
                end
            end
            ST_HIB_WAKE: begin
                if (done)
                    st_d = ST_IDLE;
            end
            ST_DOZE: begin
                if (!attn_n || (tmr_match && tmr_wake_en)) begin
                    st_d   = ST_DOZE_WAKE;
                    ld     = 1'b1;
                    ld_val = DOZE_LD;
                end
            end
            ST_DOZE_WAKE: begin
                if (done)
                    st_d = ST_IDLE;
            end
            ST_WARM: begin
                if (!rxtx_en)
                    st_d = ST_IDLE;
                else if (done)
                    st_d = dir_q ? ST_TX : ST_RX;
            end
            ST_RX, ST_TX: begin
                if (!rxtx_en)
                    st_d = ST_IDLE;
            end
            default: st_d = ST_OFF;
        endcase
    end

    seq_decode u_dec (
        .st          (st_q),
        .dir_tx      (dir_q),
        .osc_en      (osc_en),
        .spi_en      (spi_en),
        .rx_en       (rx_en),
        .tx_en       (tx_en),
        .out_of_idle (out_of_idle),
        .mode_code   (mode_code)
    );
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       attn_n,
    input logic       rxtx_en,
    input logic       rxtx_sel,
    input logic       mode_req_valid,
    input logic       mode_req_doze,
    input logic       osc_en,
    input logic       spi_en,
    input logic       rx_en,
    input logic       tx_en,
    input logic       out_of_idle,
    input logic [2:0] mode_code
);
    // R13: idle flag tracks the mode code
    a_r13_ooi_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_idle == (mode_code != 3'd3));

    // R13: receiver and transmitter exclusive
    a_r13_rx_tx_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en && tx_en));

    // R1 / R2: off and boot keep the interface and radio quiet
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd0) |-> (!spi_en && !rx_en && !tx_en));

    // R3: sleep modes are entered only from Idle
    a_r3_sleep_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_code == 3'd1 || mode_code == 3'd2) && $past(mode_code) != mode_code)
        |-> $past(mode_code) == 3'd3);

    // R3: hibernate request in Idle without a start edge
    a_r3_hib_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd3 && mode_req_valid && !mode_req_doze && !(rxtx_en && !$past(rxtx_en)))
        |=> mode_code == 3'd1);

    // R3: doze request in Idle without a start edge
    a_r3_doze_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd3 && mode_req_valid && mode_req_doze && !(rxtx_en && !$past(rxtx_en)))
        |=> mode_code == 3'd2);

    // R4: attention in Hibernate restarts the oscillator, code stays 1
    a_r4_hib_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd1 && !osc_en && !attn_n) |=> (mode_code == 3'd1 && osc_en));

    // R5: oscillator kept running in Doze
    a_r5_doze_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd2) |-> (osc_en && !spi_en));

    // R7: a start edge in Idle picks the programmed direction
    a_r7_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd3 && rxtx_en && !$past(rxtx_en))
        |=> mode_code == (rxtx_sel ? 3'd5 : 3'd4));

    // R9: enable low while active drops to Idle
    a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code >= 3'd4 && !rxtx_en) |=> mode_code == 3'd3);

    // R10: no sleep directly from an active mode
    a_r10_no_sleep_active: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code >= 3'd4) |=> (mode_code >= 3'd3));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .attn_n         (attn_n),
    .rxtx_en        (rxtx_en),
    .rxtx_sel       (rxtx_sel),
    .mode_req_valid (mode_req_valid),
    .mode_req_doze  (mode_req_doze),
    .osc_en         (osc_en),
    .spi_en         (spi_en),
    .rx_en          (rx_en),
    .tx_en          (tx_en),
    .out_of_idle    (out_of_idle),
    .mode_code      (mode_code)
);

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;
    localparam int BOOT_N = 8;
    localparam int HIB_N  = 6;
    localparam int DOZE_N = 4;
    localparam int WARM_N = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       attn_n = 1'b1;
    logic       rxtx_en = 1'b0;
    logic       rxtx_sel = 1'b0;
    logic       mode_req_valid = 1'b0;
    logic       mode_req_doze = 1'b0;
    logic       tmr_match = 1'b0;
    logic       tmr_wake_en = 1'b0;
    logic       osc_en, spi_en, rx_en, tx_en, out_of_idle;
    logic [2:0] mode_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwr_mode_seq #(
        .BOOT_CYC(BOOT_N), .HIB_WAKE_CYC(HIB_N),
        .DOZE_WAKE_CYC(DOZE_N), .WARM_CYC(WARM_N)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .rxtx_en(rxtx_en),
        .rxtx_sel(rxtx_sel), .mode_req_valid(mode_req_valid),
        .mode_req_doze(mode_req_doze), .tmr_match(tmr_match),
        .tmr_wake_en(tmr_wake_en), .osc_en(osc_en), .spi_en(spi_en),
        .rx_en(rx_en), .tx_en(tx_en), .out_of_idle(out_of_idle),
        .mode_code(mode_code)
    );

    typedef struct packed {
        logic       rxtx, sel, rqv, rqd, attn, match, wken;
        logic [3:0] hold;
        logic [2:0] emode;
        logic       erx, etx, eosc, espi;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{0,0,1,0,1,0,0, 4'd1, 3'd1, 0,0,0,0, 4'd3},  // R3 hibernate request
        '{0,0,0,0,1,0,0, 4'd3, 3'd1, 0,0,0,0, 4'd4},  // R4 stays asleep
        '{0,0,0,0,0,0,0, 4'd1, 3'd1, 0,0,1,0, 4'd4},  // R4 attention: wake begins
        '{0,0,0,0,1,0,0, 4'd5, 3'd1, 0,0,1,0, 4'd4},  // R4 one edge short
        '{0,0,0,0,1,0,0, 4'd1, 3'd3, 0,0,1,1, 4'd4},  // R4 Idle on boundary
        '{0,0,1,1,1,0,0, 4'd1, 3'd2, 0,0,1,0, 4'd3},  // R3 doze request
        '{0,0,0,0,1,1,0, 4'd3, 3'd2, 0,0,1,0, 4'd6},  // R6 match with wake disabled
        '{0,0,0,0,1,1,1, 4'd1, 3'd2, 0,0,1,0, 4'd6},  // R6 match enabled: wake begins
        '{0,0,0,0,1,0,1, 4'd3, 3'd2, 0,0,1,0, 4'd6},  // R6 one edge short
        '{0,0,0,0,1,0,1, 4'd1, 3'd3, 0,0,1,1, 4'd6},  // R6 Idle on boundary
        '{0,0,1,1,1,0,0, 4'd1, 3'd2, 0,0,1,0, 4'd3},  // R3 doze again
        '{0,0,0,0,0,0,0, 4'd1, 3'd2, 0,0,1,0, 4'd5},  // R5 attention in Doze
        '{0,0,0,0,1,0,0, 4'd4, 3'd3, 0,0,1,1, 4'd5},  // R5 Idle on boundary
        '{1,0,0,0,1,0,0, 4'd1, 3'd4, 0,0,1,1, 4'd7},  // R7 receive warm-up
        '{1,0,0,0,1,0,0, 4'd4, 3'd4, 0,0,1,1, 4'd7},  // R7 one edge short
        '{1,0,0,0,1,0,0, 4'd1, 3'd4, 1,0,1,1, 4'd7},  // R7 receiver on
        '{1,0,1,0,1,0,0, 4'd2, 3'd4, 1,0,1,1, 4'd10}, // R10 request while receiving
        '{0,0,0,0,1,0,0, 4'd1, 3'd3, 0,0,1,1, 4'd9},  // R9 drop from Receive
        '{1,1,0,0,1,0,0, 4'd6, 3'd5, 0,1,1,1, 4'd7},  // R7 transmit
        '{0,1,0,0,1,0,0, 4'd1, 3'd3, 0,0,1,1, 4'd9},  // R9 drop from Transmit
        '{1,1,0,0,1,0,0, 4'd2, 3'd5, 0,0,1,1, 4'd7},  // R7 transmit warm-up
        '{0,1,0,0,1,0,0, 4'd1, 3'd3, 0,0,1,1, 4'd9},  // R9 abort warm-up
        '{1,0,1,1,1,0,0, 4'd1, 3'd4, 0,0,1,1, 4'd11}, // R11 start beats request
        '{1,0,0,0,1,0,0, 4'd5, 3'd4, 1,0,1,1, 4'd11}, // R11 then receiving
        '{0,0,0,0,1,0,0, 4'd1, 3'd3, 0,0,1,1, 4'd9},  // R9 back to Idle
        '{0,0,0,0,0,0,0, 4'd2, 3'd3, 0,0,1,1, 4'd12}, // R12 attention in Idle
        '{0,0,0,0,1,1,1, 4'd2, 3'd3, 0,0,1,1, 4'd12}  // R12 match in Idle
    };

    task automatic check1(input int rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic check_all(input int rq, input logic [2:0] em, input logic erx,
                             input logic etx, input logic eosc, input logic espi);
        check1(rq, "mode_code", int'(mode_code), int'(em));
        check1(rq, "rx_en", int'(rx_en), int'(erx));
        check1(rq, "tx_en", int'(tx_en), int'(etx));
        check1(rq, "osc_en", int'(osc_en), int'(eosc));
        check1(rq, "spi_en", int'(spi_en), int'(espi));
        // R13 idle flag
        check1(13, "out_of_idle", int'(out_of_idle), int'(em != 3'd3));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_all(1, 3'd0, 0, 0, 0, 0); // R1 immediate Off
        repeat (3) @(negedge clk);
        check_all(1, 3'd0, 0, 0, 0, 0); // R1 held Off
        rst_n = 1'b1;
        repeat (BOOT_N) @(posedge clk);
        @(negedge clk);
        check_all(2, 3'd0, 0, 0, 1, 0); // R2 still settling
        @(posedge clk);
        @(negedge clk);
        check_all(2, 3'd3, 0, 0, 1, 1); // R2 Idle on boundary
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            rxtx_en        = TBL[i].rxtx;
            rxtx_sel       = TBL[i].sel;
            mode_req_valid = TBL[i].rqv;
            mode_req_doze  = TBL[i].rqd;
            attn_n         = TBL[i].attn;
            tmr_match      = TBL[i].match;
            tmr_wake_en    = TBL[i].wken;
            repeat (int'(TBL[i].hold)) @(posedge clk);
            @(negedge clk);
            check_all(int'(TBL[i].rq), TBL[i].emode, TBL[i].erx, TBL[i].etx,
                      TBL[i].eosc, TBL[i].espi);
        end
        attn_n = 1'b1; tmr_match = 1'b0; tmr_wake_en = 1'b0;
        mode_req_valid = 1'b0;

        // R8: enable held high through boot is not a start edge
        rxtx_en = 1'b1;
        rxtx_sel = 1'b0;
        do_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all(8, 3'd3, 0, 0, 1, 1);
        rxtx_en = 1'b0;
        @(negedge clk);
        rxtx_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_all(8, 3'd4, 0, 0, 1, 1); // R8 a fresh edge does start

        // R1: reset while active goes straight to Off
        repeat (WARM_N) @(posedge clk);
        @(negedge clk);
        check_all(7, 3'd4, 1, 0, 1, 1);
        rst_n = 1'b0;
        #1;
        check_all(1, 3'd0, 0, 0, 0, 0);
        rxtx_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule